// File: doc/BRIEF.md
# Synchronous Slave Serial Transmitter

This block sends words out on a single data line. The timing comes from a shift clock that an external master drives. The block never makes that clock. It only watches it through a synchronizer and moves the data line one bit further on each falling edge it sees. The master can then sample each bit on the next rising edge. Words go out least-significant bit first, in frames of eight bits or, in nine-bit mode, nine bits.

The host writes a word into a one-entry holding register. If the shift register is idle, the word moves into it on the next cycle. If the shift register is busy, the word waits in the holding register until the last bit of the current frame has left. The buffer-empty flag follows that hand-off and not the host write. It drops when a word enters the holding register and comes back only when the word moves into the shift register. An interrupt output reports the flag when its enable is set. A separate status output shows whether the shift register holds an unfinished frame.

Top module: `sync_slave_tx`

## Requirements
- R1: Out of reset, `shreg_empty` is 1, `buf_empty` is 1, `txd_out` is 1 and `irq` follows `irq_en`.
- R2: The transmitter is active only while `sync_sel`, `port_en` and `tx_en` are 1 and `clk_src_master` is 0. While it is inactive, host writes are dropped, and `buf_empty` and `shreg_empty` stay 1.
- R3: A write made while the holding register and the shift register are both empty sets `buf_empty` to 0 for exactly one cycle. In the next cycle the word is in the shift register: `shreg_empty` is 0 and `txd_out` shows data bit 0.
- R4: A word written while the shift register is busy stays in the holding register, and `buf_empty` stays 0 through the whole current frame.
- R5: After the last falling edge of a frame, a pending word moves into the shift register. Only at that point does `buf_empty` return to 1, and `shreg_empty` stays 0.
- R6: Bits leave least-significant first. `txd_out` changes only after a falling edge of `sclk_in` and is stable at the following rising edge.
- R7: When `nine_sel` is 1, a frame has nine bits. The ninth bit, sent last, is the value of `wr_ninth` at the time of the host write.
- R8: `irq` is 1 exactly when `buf_empty` and `irq_en` are both 1.
- R9: `shreg_empty` returns to 1 after the last falling edge of a frame (the 8th, or the 9th in nine-bit mode) when no word is pending. `txd_out` then idles at 1.
- R10: Clearing `tx_en` in the middle of a frame aborts it. `shreg_empty` and `buf_empty` become 1 and `txd_out` returns to 1.
- R11: A write made while the holding register is already full is dropped. The pending word is the one that is sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sync_sel | input | 1 | Synchronous mode select |
| port_en | input | 1 | Serial port enable |
| tx_en | input | 1 | Transmit enable |
| clk_src_master | input | 1 | Clock-source select; 0 selects slave (external clock) |
| nine_sel | input | 1 | 1 selects nine-bit frames |
| irq_en | input | 1 | Interrupt enable for the buffer-empty flag |
| wr_en | input | 1 | Host write strobe into the holding register |
| wr_data | input | 8 | Host data byte |
| wr_ninth | input | 1 | Ninth data bit, captured with the write |
| sclk_in | input | 1 | Shift clock from the external master |
| txd_out | output | 1 | Serial data out |
| buf_empty | output | 1 | Holding register empty flag |
| shreg_empty | output | 1 | Shift register empty status |
| irq | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the hand-off at the end of a frame. A second word has to be pending while the shifter is partway through, and the flag must stay low until the final falling edge, then rise together with the reload. The bench loads one word, writes a second while the first is still shifting, and checks the flag after seven master pulses and again after the eighth. It also makes a third write during that window to show that it is dropped. Aborting a frame is reached by clearing the transmit enable after a few pulses. The scoreboard's bit counter is then reset so that the partly sent frame does not count as a result.

// File: rtl/sst_pkg.sv
package sst_pkg;
  parameter int DATA_W = 8;
  localparam int FRAME_W = DATA_W + 1;
  localparam int CNT_W = $clog2(FRAME_W + 1);

  typedef struct packed {
    logic             ninth;
    logic [DATA_W-1:0] data;
  } tx_word_t;
endpackage

// File: rtl/sst_clk_sync.sv
module sst_clk_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  output logic fall
);
  logic [STAGES:0] chain_q, chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-1:0], sclk_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  // previous synchronized level high, current low
  assign fall = chain_q[STAGES] & ~chain_q[STAGES-1];
endmodule

// File: rtl/sst_holding.sv
module sst_holding
  import sst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              take,
  output logic              full,
  output tx_word_t          word
);
  logic     full_d;
  logic     cap_en;
  tx_word_t word_d;

  assign cap_en = active & wr_en & ~full;

  always_comb begin
    full_d = full;
    word_d = word;
    if (!active) begin
      full_d = 1'b0;
    end else if (take) begin
      full_d = 1'b0;
    end else if (cap_en) begin
      full_d = 1'b1;
      word_d = '{ninth: wr_ninth, data: wr_data};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full <= 1'b0;
      word <= '0;
    end else begin
      full <= full_d;
      word <= word_d;
    end
  end

  // a held word remains until it is taken or the port drops out
  p_hold_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && active) |=> full);
  // a write into a full register does not replace the held word
  p_full_write_dropped_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !take && active && wr_en) |=> $stable(word));
endmodule

// File: rtl/sst_shifter.sv
module sst_shifter
  import sst_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     active,
  input  logic     load,
  input  tx_word_t load_word,
  input  logic     nine_mode,
  input  logic     fall,
  output logic     empty,
  output logic     done,
  output logic     txd
);
  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic               nine_q, nine_d;
  logic               empty_d;
  logic [CNT_W-1:0]   last_idx;

  assign last_idx = nine_q ? CNT_W'(DATA_W) : CNT_W'(DATA_W - 1);
  assign done     = active & fall & ~empty & (cnt_q == last_idx);

  always_comb begin
    sh_d    = sh_q;
    cnt_d   = cnt_q;
    nine_d  = nine_q;
    empty_d = empty;
    if (!active) begin
      sh_d    = '1;
      cnt_d   = '0;
      empty_d = 1'b1;
    end else if (load) begin
      sh_d    = load_word;
      cnt_d   = '0;
      nine_d  = nine_mode;
      empty_d = 1'b0;
    end else if (fall && !empty) begin
      if (done) begin
        sh_d    = '1;
        cnt_d   = '0;
        empty_d = 1'b1;
      end else begin
        sh_d  = {1'b1, sh_q[FRAME_W-1:1]};
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      cnt_q  <= '0;
      nine_q <= 1'b0;
      empty  <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      cnt_q  <= cnt_d;
      nine_q <= nine_d;
      empty  <= empty_d;
    end
  end

  assign txd = sh_q[0];

  p_load_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (load && active) |=> (!empty || !active));
  p_hold_between_edges_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (active && !load && !fall) |=> $stable(txd));
  p_idle_high_r9: assert property (@(posedge clk) disable iff (!rst_n)
    empty |-> txd);
endmodule

// File: rtl/sync_slave_tx.sv
module sync_slave_tx
  import sst_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sync_sel,
  input  logic              port_en,
  input  logic              tx_en,
  input  logic              clk_src_master,
  input  logic              nine_sel,
  input  logic              irq_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              wr_ninth,
  input  logic              sclk_in,
  output logic              txd_out,
  output logic              buf_empty,
  output logic              shreg_empty,
  output logic              irq
);
  logic     active;
  logic     fall;
  logic     hold_full;
  tx_word_t hold_word;
  logic     sh_empty;
  logic     sh_done;
  logic     take;
  tx_word_t load_word;

  assign active = sync_sel & port_en & tx_en & ~clk_src_master;

  sst_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk_in (sclk_in),
    .fall    (fall)
  );

  sst_holding u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .active   (active),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .wr_ninth (wr_ninth),
    .take     (take),
    .full     (hold_full),
    .word     (hold_word)
  );

  // hand-off: into an idle shifter at once, otherwise on the final edge
  assign take = active & hold_full & (sh_empty | sh_done);

  always_comb begin
    load_word = hold_word;
    if (!nine_sel) load_word.ninth = 1'b1;
  end

  sst_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .active    (active),
    .load      (take),
    .load_word (load_word),
    .nine_mode (nine_sel),
    .fall      (fall),
    .empty     (sh_empty),
    .done      (sh_done),
    .txd       (txd_out)
  );

  assign buf_empty   = ~hold_full;
  assign shreg_empty = sh_empty;
  assign irq         = buf_empty & irq_en;

  p_flag_on_handoff_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(buf_empty) && active && $past(active)) |-> $past(take));
  p_inactive_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !active |=> (shreg_empty && buf_empty && txd_out));
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(tx_en) |=> (shreg_empty && buf_empty));
  p_shift_needs_edge_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!shreg_empty && !fall && active && $past(active)) |-> !$fell(shreg_empty) || $past(take));
endmodule

// File: tb/sync_slave_tx_bench.sv
module sync_slave_tx_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_sel = 1'b0, port_en = 1'b0, tx_en = 1'b0, clk_src_master = 1'b0;
  logic nine_sel = 1'b0, irq_en = 1'b0, wr_en = 1'b0, wr_ninth = 1'b0;
  logic [7:0] wr_data = '0;
  logic sclk_in = 1'b0;
  logic txd_out, buf_empty, shreg_empty, irq;

  int checks = 0;
  int errors = 0;
  int q_len[$];
  logic [8:0] q_bits[$];
  int mon_cnt = 0;
  logic [8:0] mon_bits = '0;
  bit done_flag = 1'b0;

  always #4 clk = ~clk;

  sync_slave_tx u_sync_slave_tx (
    .clk(clk), .rst_n(rst_n), .sync_sel(sync_sel), .port_en(port_en),
    .tx_en(tx_en), .clk_src_master(clk_src_master), .nine_sel(nine_sel),
    .irq_en(irq_en), .wr_en(wr_en), .wr_data(wr_data), .wr_ninth(wr_ninth),
    .sclk_in(sclk_in), .txd_out(txd_out), .buf_empty(buf_empty),
    .shreg_empty(shreg_empty), .irq(irq)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [7:0] d, input logic n9, input bit expect_sent, input int len);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_ninth = n9;
    @(negedge clk);
    wr_en = 1'b0;
    if (expect_sent) begin
      q_len.push_back(len);
      q_bits.push_back({n9, d});
    end
  endtask

  task automatic pulse();
    sclk_in = 1'b1;
    repeat (5) @(negedge clk);
    sclk_in = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  // monitor: samples the line as the master does, on each rising shift edge
  always @(posedge sclk_in) begin
    if (q_len.size() != 0) begin
      mon_bits[mon_cnt] = txd_out;
      mon_cnt++;
      if (mon_cnt == q_len[0]) begin
        logic [8:0] exp_w;
        logic [8:0] got_w;
        exp_w = q_bits[0];
        got_w = mon_bits;
        if (q_len[0] == 8) begin
          exp_w[8] = 1'b0;
          got_w[8] = 1'b0;
        end
        chk(got_w == exp_w, "R6/R7 frame content", got_w, exp_w);
        void'(q_len.pop_front());
        void'(q_bits.pop_front());
        mon_cnt = 0;
        mon_bits = '0;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done_flag) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(shreg_empty == 1'b1, "R1 shreg_empty", shreg_empty, 1);
    chk(buf_empty == 1'b1, "R1 buf_empty", buf_empty, 1);
    chk(txd_out == 1'b1, "R1 txd_out", txd_out, 1);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rst_n = 1'b1;
    @(negedge clk);
    sync_sel = 1'b1; port_en = 1'b1; tx_en = 1'b1; clk_src_master = 1'b1;
    // R2: master clock source selected, write is dropped
    host_write(8'h5A, 1'b0, 1'b0, 8);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R2 buf_empty while inactive", buf_empty, 1);
    chk(shreg_empty == 1'b1, "R2 shreg_empty while inactive", shreg_empty, 1);
    clk_src_master = 1'b0;
    irq_en = 1'b1;
    @(negedge clk);
    chk(irq == 1'b1, "R8 irq with flag set", irq, 1);
    // R3: direct load into idle shifter
    @(negedge clk);
    wr_en = 1'b1; wr_data = 8'hA5; wr_ninth = 1'b0;
    @(negedge clk);
    wr_en = 1'b0;
    q_len.push_back(8); q_bits.push_back({1'b0, 8'hA5});
    chk(buf_empty == 1'b0, "R3 flag low one cycle", buf_empty, 0);
    chk(irq == 1'b0, "R8 irq follows flag", irq, 0);
    @(negedge clk);
    chk(buf_empty == 1'b1, "R3 flag back after load", buf_empty, 1);
    chk(shreg_empty == 1'b0, "R3 shifter loaded", shreg_empty, 0);
    chk(txd_out == 1'b1, "R3 bit0 on line", txd_out, 1);
    // R4 / R11: pending word, then a dropped write
    host_write(8'h3C, 1'b0, 1'b1, 8);
    chk(buf_empty == 1'b0, "R4 flag low while pending", buf_empty, 0);
    host_write(8'hFF, 1'b0, 1'b0, 8);
    pulse();
    chk(txd_out == 1'b0, "R6 bit1 after first fall", txd_out, 0);
    repeat (6) pulse();
    chk(buf_empty == 1'b0, "R4 flag low before last edge", buf_empty, 0);
    pulse();
    chk(buf_empty == 1'b1, "R5 flag set at hand-off", buf_empty, 1);
    chk(shreg_empty == 1'b0, "R5 shifter reloaded", shreg_empty, 0);
    repeat (8) pulse();
    chk(shreg_empty == 1'b1, "R9 empty after last bit", shreg_empty, 1);
    chk(txd_out == 1'b1, "R9 idle line", txd_out, 1);
    chk(q_len.size() == 0, "R11 dropped word not sent", q_len.size(), 0);
    // R7: nine-bit frames
    nine_sel = 1'b1;
    host_write(8'h81, 1'b1, 1'b1, 9);
    @(negedge clk);
    repeat (8) pulse();
    chk(shreg_empty == 1'b0, "R7 ninth bit still pending", shreg_empty, 0);
    chk(txd_out == 1'b1, "R7 ninth bit value", txd_out, 1);
    pulse();
    chk(shreg_empty == 1'b1, "R7 empty after ninth", shreg_empty, 1);
    host_write(8'h7E, 1'b0, 1'b1, 9);
    @(negedge clk);
    repeat (9) pulse();
    chk(shreg_empty == 1'b1, "R9 empty after nine-bit frame", shreg_empty, 1);
    nine_sel = 1'b0;
    // R10: abort mid frame
    host_write(8'h55, 1'b0, 1'b0, 8);
    @(negedge clk);
    repeat (3) pulse();
    tx_en = 1'b0;
    @(negedge clk);
    mon_cnt = 0; mon_bits = '0;
    chk(shreg_empty == 1'b1, "R10 shifter cleared", shreg_empty, 1);
    chk(buf_empty == 1'b1, "R10 flag set", buf_empty, 1);
    chk(txd_out == 1'b1, "R10 line idle", txd_out, 1);
    tx_en = 1'b1;
    irq_en = 1'b0;
    @(negedge clk);
    chk(irq == 1'b0, "R8 irq masked", irq, 0);
    done_flag = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule